// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block gathers one-cycle event strobes from the sub-modules of a multi-port network switch and drives one registered interrupt pin. Each strobe sets a sticky status bit. An event reaches the pin only if it passes every gate on its path. These gates are the source's own mask, the mask of any middle tier, the group enable in the top-level enable register, and the global pin enable in the configuration register.

There are two groups. The precision-timestamp group is a two-tier path. One combined register holds its source status bits and its source enables, and the result feeds a single top-level status bit. The switch-fabric group is a three-tier path. The buffer-manager and switch-engine pending/mask pairs, plus three port-MAC pairs that have no sources, feed a middle pending/mask pair, and that pair feeds a second top-level bit. Upper-tier status bits are not stored. They always show the OR of the enabled bits below them, so they clear on their own once the host has cleared the leaf bits.

The host reaches the registers through a plain write strobe, address and data bus, and reads them back combinationally. Every pin is a plain control or status pin: no port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, every status, mask, enable and configuration register reads 0. The pin polarity is then active-low, so irq_o is 1 (deasserted).
- R2: A strobe on a source sets its status bit, and the bit holds until the host writes 1 to that position. Writing 0 leaves it unchanged. The timestamp register is at address 3. Its status bit i follows ts_evt_i[i]: bit 2p is transmit capture on port p, bit 2p+1 is receive capture on port p, bits 6 and 7 are the two GPIO captures, and bit 8 is the timer. Its enable for source i is at bit 16+i and is read/write.
- R3: If a strobe and a host write of 1 hit the same status bit in the same cycle, the bit ends up set.
- R4: Top-level status (address 0) bit 29 reads as the OR of the timestamp status bits ANDed with their enables. It returns to 0 once those enabled bits are cleared.
- R5: Buffer-manager pending is at address 6 (bit 0 status-A, bit 1 status-B) with its mask at 7. Switch-engine pending is at 8, bit 0, with its mask at 9. Middle pending (address 4) bit 0 is the OR of the masked buffer-manager bits and bit 1 is the masked switch-engine bit. Its mask is at address 5. Top-level bit 28 is the OR of middle pending ANDed with middle mask.
- R6: Port-MAC p has a pending register at address 16+2p that always reads 0 and ignores writes. Its mask register at 17+2p keeps bit 0 and reads it back. Middle pending bits 2..4 always read 0, so no MAC setting can raise the pin.
- R7: The top-level enable register (address 1) uses bit 29 for the timestamp group and bit 28 for the fabric group. The pin asserts only if an enabled top-level bit is set AND configuration (address 2) bit 8 is 1. With bit 8 at 0 the pin stays deasserted.
- R8: Configuration bit 0 selects the pin level: 1 means asserted high, 0 means asserted low.
- R9: When every enable on its path is set, a strobe sampled at a rising edge asserts irq_o at the next rising edge after that one.
- R10: Writes to the derived registers at addresses 0 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 5 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ts_evt_i | input | 9 | Timestamp-group event strobes |
| bm_evt_i | input | 2 | Buffer-manager event strobes (bit 0 A, bit 1 B) |
| se_evt_i | input | 1 | Switch-engine event strobe |
| irq_o | output | 1 | Registered interrupt pin |

## Verification
The bench drives a strobe in the same cycle as a write-one-clear to the same bit. A design where clear wins would lose the event, and the bench sees a zero on readback. It blocks each tier in turn with a leaf mask, a middle mask, a group enable and the global enable. A design that skips one gate would raise the pin while that gate is off. Pin samples on both sides of each strobe pin down the two-edge latency, and an extra or missing register stage shows up as a pin change one cycle early or late. The bench also writes all ones to the derived and MAC pending registers and then reads them back, which catches a design that stores those writes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW = 32;
  localparam int AW = 5;

  // top-level bit positions (shared by status and enable)
  localparam int TOP_TS_BIT  = 29;
  localparam int TOP_FAB_BIT = 28;

  // configuration bits
  localparam int CFG_EN_BIT  = 8;
  localparam int CFG_POL_BIT = 0;

  // timestamp register: enables sit above the status bits
  localparam int TS_EN_LSB = 16;

  // middle-tier bit positions
  localparam int MID_BM   = 0;
  localparam int MID_SE   = 1;
  localparam int MID_MAC0 = 2;

  localparam logic [AW-1:0] A_TOP_STAT = 5'd0;
  localparam logic [AW-1:0] A_TOP_EN   = 5'd1;
  localparam logic [AW-1:0] A_CFG      = 5'd2;
  localparam logic [AW-1:0] A_TS       = 5'd3;
  localparam logic [AW-1:0] A_MID_PEND = 5'd4;
  localparam logic [AW-1:0] A_MID_MASK = 5'd5;
  localparam logic [AW-1:0] A_BM_PEND  = 5'd6;
  localparam logic [AW-1:0] A_BM_MASK  = 5'd7;
  localparam logic [AW-1:0] A_SE_PEND  = 5'd8;
  localparam logic [AW-1:0] A_SE_MASK  = 5'd9;
  localparam int            A_MAC_BASE = 16;

  function automatic logic [AW-1:0] mac_pend_addr(input int p);
    return AW'(A_MAC_BASE + 2 * p);
  endfunction

  function automatic logic [AW-1:0] mac_mask_addr(input int p);
    return AW'(A_MAC_BASE + 2 * p + 1);
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  // sticky status; a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= (stat_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_rw_field.sv
module irq_rw_field #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic en_i,
  input  logic pol_i,
  output logic irq_o
);
  // reset level matches the active-low default polarity (deasserted = 1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b1;
    else        irq_o <= (req_i && en_i) ? pol_i : ~pol_i;
  end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int N_GPIO  = 2,
  parameter int BM_W    = 2,
  parameter int SE_W    = 1,
  localparam int TS_W   = 2 * N_PORTS + N_GPIO + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [TS_W-1:0] ts_evt_i,
  input  logic [BM_W-1:0] bm_evt_i,
  input  logic [SE_W-1:0] se_evt_i,
  output logic            irq_o
);
  localparam int MID_W = MID_MAC0 + N_PORTS;

  // write decode
  logic we_top_en, we_cfg, we_ts, we_mid_mask;
  logic we_bm_pend, we_bm_mask, we_se_pend, we_se_mask;
  assign we_top_en   = reg_we && (reg_addr == A_TOP_EN);
  assign we_cfg      = reg_we && (reg_addr == A_CFG);
  assign we_ts       = reg_we && (reg_addr == A_TS);
  assign we_mid_mask = reg_we && (reg_addr == A_MID_MASK);
  assign we_bm_pend  = reg_we && (reg_addr == A_BM_PEND);
  assign we_bm_mask  = reg_we && (reg_addr == A_BM_MASK);
  assign we_se_pend  = reg_we && (reg_addr == A_SE_PEND);
  assign we_se_mask  = reg_we && (reg_addr == A_SE_MASK);

  // timestamp group: combined status/enable register
  logic [TS_W-1:0] ts_stat, ts_en;
  irq_sticky_bank #(.W(TS_W)) u_ts_stat (
    .clk(clk), .rst_n(rst_n), .set_i(ts_evt_i),
    .clr_i(we_ts ? reg_wdata[TS_W-1:0] : '0), .stat_o(ts_stat)
  );
  irq_rw_field #(.W(TS_W)) u_ts_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_ts),
    .d_i(reg_wdata[TS_EN_LSB +: TS_W]), .q_o(ts_en)
  );

  // fabric leaf tier: buffer manager
  logic [BM_W-1:0] bm_pend, bm_mask;
  irq_sticky_bank #(.W(BM_W)) u_bm_pend (
    .clk(clk), .rst_n(rst_n), .set_i(bm_evt_i),
    .clr_i(we_bm_pend ? reg_wdata[BM_W-1:0] : '0), .stat_o(bm_pend)
  );
  irq_rw_field #(.W(BM_W)) u_bm_mask (
    .clk(clk), .rst_n(rst_n), .we_i(we_bm_mask),
    .d_i(reg_wdata[BM_W-1:0]), .q_o(bm_mask)
  );

  // fabric leaf tier: switch engine
  logic [SE_W-1:0] se_pend, se_mask;
  irq_sticky_bank #(.W(SE_W)) u_se_pend (
    .clk(clk), .rst_n(rst_n), .set_i(se_evt_i),
    .clr_i(we_se_pend ? reg_wdata[SE_W-1:0] : '0), .stat_o(se_pend)
  );
  irq_rw_field #(.W(SE_W)) u_se_mask (
    .clk(clk), .rst_n(rst_n), .we_i(we_se_mask),
    .d_i(reg_wdata[SE_W-1:0]), .q_o(se_mask)
  );

  // fabric leaf tier: port MACs (mask storage only, no sources)
  logic [N_PORTS-1:0] mac_mask;
  logic [MID_W-1:0]   mid_pend, mid_mask;
  for (genvar p = 0; p < N_PORTS; p++) begin : g_mac
    irq_rw_field #(.W(1)) u_mac_mask (
      .clk(clk), .rst_n(rst_n),
      .we_i(reg_we && (reg_addr == mac_mask_addr(p))),
      .d_i(reg_wdata[0]), .q_o(mac_mask[p])
    );
    assign mid_pend[MID_MAC0 + p] = 1'b0;
  end

  // middle tier, derived from enabled leaves
  assign mid_pend[MID_BM] = |(bm_pend & bm_mask);
  assign mid_pend[MID_SE] = |(se_pend & se_mask);
  irq_rw_field #(.W(MID_W)) u_mid_mask (
    .clk(clk), .rst_n(rst_n), .we_i(we_mid_mask),
    .d_i(reg_wdata[MID_W-1:0]), .q_o(mid_mask)
  );

  // top tier
  logic ts_grp, fab_grp;
  logic [1:0] top_en; // [1] timestamp, [0] fabric
  assign ts_grp  = |(ts_stat & ts_en);
  assign fab_grp = |(mid_pend & mid_mask);
  irq_rw_field #(.W(2)) u_top_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_top_en),
    .d_i({reg_wdata[TOP_TS_BIT], reg_wdata[TOP_FAB_BIT]}), .q_o(top_en)
  );

  // configuration: {pin enable, polarity}
  logic [1:0] cfg_q;
  logic cfg_irq_en, cfg_pol;
  irq_rw_field #(.W(2)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(we_cfg),
    .d_i({reg_wdata[CFG_EN_BIT], reg_wdata[CFG_POL_BIT]}), .q_o(cfg_q)
  );
  assign cfg_irq_en = cfg_q[1];
  assign cfg_pol    = cfg_q[0];

  logic irq_req;
  assign irq_req = (ts_grp && top_en[1]) || (fab_grp && top_en[0]);

  irq_pin_drive u_pin (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req),
    .en_i(cfg_irq_en), .pol_i(cfg_pol), .irq_o(irq_o)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TOP_STAT: begin
        reg_rdata[TOP_TS_BIT]  = ts_grp;
        reg_rdata[TOP_FAB_BIT] = fab_grp;
      end
      A_TOP_EN: begin
        reg_rdata[TOP_TS_BIT]  = top_en[1];
        reg_rdata[TOP_FAB_BIT] = top_en[0];
      end
      A_CFG: begin
        reg_rdata[CFG_EN_BIT]  = cfg_irq_en;
        reg_rdata[CFG_POL_BIT] = cfg_pol;
      end
      A_TS: begin
        reg_rdata[TS_W-1:0]           = ts_stat;
        reg_rdata[TS_EN_LSB +: TS_W]  = ts_en;
      end
      A_MID_PEND: reg_rdata[MID_W-1:0] = mid_pend;
      A_MID_MASK: reg_rdata[MID_W-1:0] = mid_mask;
      A_BM_PEND:  reg_rdata[BM_W-1:0]  = bm_pend;
      A_BM_MASK:  reg_rdata[BM_W-1:0]  = bm_mask;
      A_SE_PEND:  reg_rdata[SE_W-1:0]  = se_pend;
      A_SE_MASK:  reg_rdata[SE_W-1:0]  = se_mask;
      default: begin
        for (int p = 0; p < N_PORTS; p++) begin
          if (reg_addr == mac_mask_addr(p)) reg_rdata[0] = mac_mask[p];
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int TS_W    = 9,
  parameter int BM_W    = 2,
  parameter int MID_W   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic [TS_W-1:0] ts_evt_i,
  input logic [BM_W-1:0] bm_evt_i,
  input logic            irq_o,
  input logic [TS_W-1:0] ts_stat,
  input logic [TS_W-1:0] ts_en,
  input logic [BM_W-1:0] bm_pend,
  input logic [BM_W-1:0] bm_mask,
  input logic [MID_W-1:0] mid_mask,
  input logic [1:0]      top_en,
  input logic            cfg_irq_en,
  input logic            cfg_pol
);
  logic ts_hit, bm_hit;
  assign ts_hit = (|(ts_evt_i & ts_en)) && top_en[1] && cfg_irq_en;
  assign bm_hit = (|(bm_evt_i & bm_mask)) && mid_mask[MID_BM] && top_en[0] && cfg_irq_en;

  // R3: a strobe always leaves its status bit set, even against a clear
  a_r3_ts_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_evt_i != '0) |=> ((ts_stat & $past(ts_evt_i)) == $past(ts_evt_i)));
  a_r3_bm_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_evt_i != '0) |=> ((bm_pend & $past(bm_evt_i)) == $past(bm_evt_i)));

  // R2: without a write or strobe the status holds
  a_r2_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && ts_evt_i == '0) |=> $stable(ts_stat));

  // R7: global enable off keeps the pin at its inactive level
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |=> (irq_o == !$past(cfg_pol)));

  // R9: fully enabled strobe reaches the pin one edge after it is sampled
  a_r9_ts_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_hit && !reg_we) |-> ##2 (irq_o == $past(cfg_pol)));
  a_r9_bm_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_hit && !reg_we) |-> ##2 (irq_o == $past(cfg_pol)));

  // R6: MAC pending registers read zero
  for (genvar p = 0; p < N_PORTS; p++) begin : g_mac_chk
    a_r6_mac_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == mac_pend_addr(p)) |-> (reg_rdata == '0));
  end
endmodule

bind irq_agg_ctrl irq_agg_chk #(
  .N_PORTS(N_PORTS), .TS_W(TS_W), .BM_W(BM_W), .MID_W(MID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ts_evt_i(ts_evt_i), .bm_evt_i(bm_evt_i),
  .irq_o(irq_o), .ts_stat(ts_stat), .ts_en(ts_en), .bm_pend(bm_pend),
  .bm_mask(bm_mask), .mid_mask(mid_mask), .top_en(top_en),
  .cfg_irq_en(cfg_irq_en), .cfg_pol(cfg_pol)
);

// File: tb/sim_irq_agg_ctrl.sv
`timescale 1ns/1ps
module sim_irq_agg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  ts_evt = '0;
  logic [1:0]  bm_evt = '0;
  logic [0:0]  se_evt = '0;
  logic        irq_o;

  always #4 clk = ~clk; // 125 MHz

  irq_agg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ts_evt_i(ts_evt),
    .bm_evt_i(bm_evt), .se_evt_i(se_evt), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit pol_b = 1'b0;
  bit done = 1'b0;

  function automatic logic lvl(input bit asserted);
    return pol_b ? asserted : !asserted;
  endfunction

  // monitor: pops one expected item per cycle, sampled just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (it.is_irq) begin
        if (irq_o !== it.exp[0]) begin
          bad++;
          $display("FAIL %s irq_o act=%0b exp=%0b", it.tag, irq_o, it.exp[0]);
        end
      end else if (reg_rdata !== it.exp) begin
        bad++;
        $display("FAIL %s rdata act=%08h exp=%08h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  // grp: 0 timestamp, 1 buffer manager, 2 switch engine
  task automatic pulse(input int grp, input logic [8:0] bits,
                       input logic e1, input logic e2, input string tag);
    item_t it;
    @(negedge clk);
    if (grp == 0) ts_evt = bits;
    else if (grp == 1) bm_evt = bits[1:0];
    else se_evt = bits[0:0];
    it.is_irq = 1'b1; it.exp = {31'd0, e1}; it.tag = {tag, " edge1"};
    q.push_back(it);
    @(negedge clk);
    ts_evt = '0; bm_evt = '0; se_evt = '0;
    it.exp = {31'd0, e2}; it.tag = {tag, " edge2"};
    q.push_back(it);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b1, "R1 pin deasserted");
    for (int a = 0; a < 10; a++) chk_rd(5'(a), 32'h0, "R1 reset reg");
    chk_rd(5'd17, 32'h0, "R1 reset mac mask");

    // timestamp path, active-low
    wr(5'd3, 32'h0008_0000);
    wr(5'd1, 32'h2000_0000);
    wr(5'd2, 32'h0000_0100);
    chk_rd(5'd2, 32'h0000_0100, "R7 cfg readback");
    pulse(0, 9'h008, lvl(0), lvl(1), "R9 ts latency");
    chk_rd(5'd3, 32'h0008_0008, "R2 ts status set");
    chk_rd(5'd0, 32'h2000_0000, "R4 top ts bit");
    wr(5'd3, 32'h0008_0000);
    chk_rd(5'd3, 32'h0008_0008, "R2 write zero keeps");
    wr(5'd3, 32'h0008_0008);
    chk_rd(5'd3, 32'h0008_0000, "R2 w1c clears");
    chk_rd(5'd0, 32'h0, "R4 top auto clear");
    chk_irq(lvl(0), "R7 pin released");

    // disabled timestamp source
    pulse(0, 9'h100, lvl(0), lvl(0), "R4 disabled source");
    chk_rd(5'd3, 32'h0008_0100, "R2 timer status");
    chk_rd(5'd0, 32'h0, "R4 masked not in top");
    wr(5'd3, 32'h0008_0100);
    chk_rd(5'd3, 32'h0008_0000, "R2 timer cleared");

    // R3 set beats clear
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd3; reg_wdata = 32'h0008_0008; ts_evt = 9'h008;
    @(negedge clk);
    reg_we = 1'b0; ts_evt = '0;
    chk_rd(5'd3, 32'h0008_0008, "R3 set wins");
    wr(5'd3, 32'h0008_0008);
    chk_rd(5'd3, 32'h0008_0000, "R3 cleared after");
    chk_irq(lvl(0), "R3 pin released");

    // R5 fabric path
    wr(5'd7, 32'h2);
    wr(5'd5, 32'h1);
    wr(5'd1, 32'h3000_0000);
    pulse(1, 9'h002, lvl(0), lvl(1), "R9 bm latency");
    chk_rd(5'd6, 32'h2, "R5 bm pend");
    chk_rd(5'd4, 32'h1, "R5 mid pend bm");
    chk_rd(5'd0, 32'h1000_0000, "R5 top fab bit");
    pulse(1, 9'h001, lvl(1), lvl(1), "R5 bm second");
    chk_rd(5'd6, 32'h3, "R5 bm both pend");
    wr(5'd6, 32'h2);
    chk_rd(5'd6, 32'h1, "R5 bm clear b");
    chk_rd(5'd4, 32'h0, "R5 masked a not mid");
    chk_rd(5'd0, 32'h0, "R5 top cleared");
    chk_irq(lvl(0), "R5 pin released");
    wr(5'd6, 32'h1);
    chk_rd(5'd6, 32'h0, "R5 bm all clear");

    // switch engine with middle mask closed
    wr(5'd9, 32'h1);
    pulse(2, 9'h001, lvl(0), lvl(0), "R5 mid mask blocks");
    chk_rd(5'd8, 32'h1, "R5 se pend");
    chk_rd(5'd4, 32'h2, "R5 mid pend se");
    chk_rd(5'd0, 32'h0, "R5 top blocked");
    wr(5'd5, 32'h3);
    chk_rd(5'd0, 32'h1000_0000, "R5 top after mid mask");
    chk_irq(lvl(1), "R5 pin after mid mask");

    // R10 derived registers ignore writes
    wr(5'd0, 32'hFFFF_FFFF);
    chk_rd(5'd0, 32'h1000_0000, "R10 top stat write");
    wr(5'd4, 32'hFFFF_FFFF);
    chk_rd(5'd4, 32'h2, "R10 mid pend write");

    // R7 / R8 global enable and polarity
    wr(5'd2, 32'h0);
    chk_irq(1'b1, "R7 global off low-pol");
    wr(5'd2, 32'h1);
    pol_b = 1'b1;
    chk_irq(1'b0, "R7 global off high-pol");
    wr(5'd2, 32'h101);
    chk_irq(1'b1, "R8 active high");
    wr(5'd8, 32'h1);
    chk_rd(5'd8, 32'h0, "R5 se cleared");
    chk_irq(1'b0, "R8 high-pol deasserted");
    pulse(0, 9'h008, 1'b0, 1'b1, "R9 ts latency high-pol");
    wr(5'd3, 32'h0008_0008);
    chk_irq(1'b0, "R9 pin released");

    // R6 MAC registers
    wr(5'd17, 32'h1);
    chk_rd(5'd17, 32'h1, "R6 mac mask readback");
    chk_rd(5'd19, 32'h0, "R6 other mac mask");
    wr(5'd16, 32'hFFFF_FFFF);
    chk_rd(5'd16, 32'h0, "R6 mac pend zero");
    wr(5'd5, 32'h1F);
    chk_rd(5'd4, 32'h0, "R6 mid mac bits zero");
    chk_irq(1'b0, "R6 mac no irq");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule